// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block lives inside a behavioural model of a word-wide parallel flash array. It watches the synchronous bus writes that reach the array, each an address word plus a data word. It recognises the guarded multi-write sequences that change the array: programming one word, erasing one 2K-word sector, erasing the whole array, and entering or leaving the identification mode. A command is only accepted after a fixed two-write key pattern at two fixed addresses. The erase commands need that key pattern a second time.

When a sequence completes, the decoder raises a one-cycle start pulse. With the pulse it gives the operation type and the latched target address and data, which the array model then acts on. It also holds a flag for identification mode, and while that flag is set it answers reads of the two identification words. While the array reports that a program or erase is running, every write is ignored, including the identification exit.

Top module: `cmdseq_decoder`

## Requirements
- R1: During and after a synchronous active-high reset, `start_o` and `id_mode_o` are 0, `op_o` is 0 and `id_valid_o` is 0.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any write (A, D), give one `start_o` pulse in the cycle after the clock edge that samples the fourth write. That pulse carries `op_o`=1 (program), `op_addr_o`=A and `op_data_o`=D.
- R3: In command writes only address bits 14..0 and data bits 7..0 are compared. Address bit 15 and data bits 15..8 may take any value.
- R4: Six writes give `op_o`=3 (chip erase) with `op_addr_o`=0 and `op_data_o`=0. The writes are AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h.
- R5: The same five-write prefix, followed by 30h at any address, gives `op_o`=2 (sector erase). `op_addr_o` then holds the sixth write's address bits 15..11 with bits 10..0 cleared, and `op_data_o`=0.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h set `id_mode_o`. While it is set, a read address with bits 15..1 zero returns 00BFh for bit 0 = 0 and 2788h for bit 0 = 1, with `id_valid_o`=1, one cycle after the address is sampled. Any other read address, or a read outside the mode, returns `id_valid_o`=0 and `id_rdata_o`=0.
- R7: AAh@5555h, 55h@2AAAh, F0h@5555h clear `id_mode_o`.
- R8: A single write of F0h at any address, seen when no sequence is in progress, clears `id_mode_o`.
- R9: A write that does not match the expected step returns the decoder to idle without starting an operation. That same write is not taken as the first step of a new sequence.
- R10: A write seen while `busy_i` is 1 is ignored. It neither advances nor breaks a sequence, and it does not change `id_mode_o`.
- R11: `start_o` is never high in two consecutive cycles, and it is low in any cycle that follows a cycle with no accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle when high |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 16 | Write data |
| busy_i | input | 1 | Array busy with an internal program or erase |
| rd_addr_i | input | 16 | Read address for identification words |
| start_o | output | 1 | One-cycle operation start pulse |
| op_o | output | 2 | Operation: 1 program, 2 sector erase, 3 chip erase |
| op_addr_o | output | 16 | Latched target address |
| op_data_o | output | 16 | Latched program data |
| id_mode_o | output | 1 | Identification mode flag |
| id_valid_o | output | 1 | Identification word is being returned |
| id_rdata_o | output | 16 | Identification read data |

## Verification
A wrong sequence state shows up at the latest on the write that should finish the sequence. A stuck or skipped step either fires `start_o` one write too early, or the pulse is missing in the cycle after the final write. A wrong abort target is exposed by the key-then-repeated-key pattern, where re-evaluating the breaking write would give a false program pulse four writes later. Mishandled busy writes show as a lost pulse in a sequence that has an ignored write in its middle, or as an identification flag that drops one cycle after a busy exit write.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [1:0] {
    OP_NONE         = 2'd0,
    OP_PROGRAM      = 2'd1,
    OP_SECTOR_ERASE = 2'd2,
    OP_CHIP_ERASE   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PGM_ARM,
    ST_ERS_KEY0,
    ST_ERS_KEY1,
    ST_ERS_KEY2
  } seq_st_e;

  // Decoded properties of one bus write.
  typedef struct packed {
    logic key_first;   // AA at first key address
    logic key_second;  // 55 at second key address
    logic arm_pgm;     // A0 at first key address
    logic arm_erase;   // 80 at first key address
    logic id_enter;    // 90 at first key address
    logic id_leave;    // F0 at first key address
    logic erase_all;   // 10 at first key address
    logic erase_sect;  // 30 at any address
    logic leave_any;   // F0 at any address
  } hit_t;

  localparam logic [7:0] CODE_KEY_FIRST  = 8'hAA;
  localparam logic [7:0] CODE_KEY_SECOND = 8'h55;
  localparam logic [7:0] CODE_PGM        = 8'hA0;
  localparam logic [7:0] CODE_ERASE      = 8'h80;
  localparam logic [7:0] CODE_ID_IN      = 8'h90;
  localparam logic [7:0] CODE_ID_OUT     = 8'hF0;
  localparam logic [7:0] CODE_ALL        = 8'h10;
  localparam logic [7:0] CODE_SECT       = 8'h30;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output hit_t              hit_o
);
  localparam int CMP_W = ADDR_W - 1;

  logic       at_a;
  logic       at_b;
  logic [7:0] code;

  assign at_a = (addr_i[CMP_W-1:0] == KEY_ADDR_A[CMP_W-1:0]);
  assign at_b = (addr_i[CMP_W-1:0] == KEY_ADDR_B[CMP_W-1:0]);
  assign code = data_i[7:0];

  always_comb begin
    hit_o            = '0;
    hit_o.key_first  = at_a && (code == CODE_KEY_FIRST);
    hit_o.key_second = at_b && (code == CODE_KEY_SECOND);
    hit_o.arm_pgm    = at_a && (code == CODE_PGM);
    hit_o.arm_erase  = at_a && (code == CODE_ERASE);
    hit_o.id_enter   = at_a && (code == CODE_ID_IN);
    hit_o.id_leave   = at_a && (code == CODE_ID_OUT);
    hit_o.erase_all  = at_a && (code == CODE_ALL);
    hit_o.erase_sect = (code == CODE_SECT);
    hit_o.leave_any  = (code == CODE_ID_OUT);
  end

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SECT_IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  hit_t              hit_i,
  output logic              start_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              id_mode_o
);
  localparam int OFS_W = ADDR_W - SECT_IDX_W;

  seq_st_e           state_q;
  logic              accept;
  logic [ADDR_W-1:0] sect_base;

  assign accept    = wr_en_i && !busy_i;
  assign sect_base = {addr_i[ADDR_W-1 -: SECT_IDX_W], {OFS_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      start_o   <= 1'b0;
      op_o      <= OP_NONE;
      op_addr_o <= '0;
      op_data_o <= '0;
      id_mode_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (accept) begin
        state_q <= ST_IDLE;
        unique case (state_q)
          ST_IDLE: begin
            if (hit_i.key_first)
              state_q <= ST_KEY1;
            else if (hit_i.leave_any)
              id_mode_o <= 1'b0;
          end
          ST_KEY1: begin
            if (hit_i.key_second) state_q <= ST_KEY2;
          end
          ST_KEY2: begin
            if (hit_i.arm_pgm)        state_q <= ST_PGM_ARM;
            else if (hit_i.arm_erase) state_q <= ST_ERS_KEY0;
            else if (hit_i.id_enter)  id_mode_o <= 1'b1;
            else if (hit_i.id_leave)  id_mode_o <= 1'b0;
          end
          ST_PGM_ARM: begin
            start_o   <= 1'b1;
            op_o      <= OP_PROGRAM;
            op_addr_o <= addr_i;
            op_data_o <= data_i;
          end
          ST_ERS_KEY0: begin
            if (hit_i.key_first) state_q <= ST_ERS_KEY1;
          end
          ST_ERS_KEY1: begin
            if (hit_i.key_second) state_q <= ST_ERS_KEY2;
          end
          ST_ERS_KEY2: begin
            if (hit_i.erase_all) begin
              start_o   <= 1'b1;
              op_o      <= OP_CHIP_ERASE;
              op_addr_o <= '0;
              op_data_o <= '0;
            end else if (hit_i.erase_sect) begin
              start_o   <= 1'b1;
              op_o      <= OP_SECTOR_ERASE;
              op_addr_o <= sect_base;
              op_data_o <= '0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/id_reader.sv
module id_reader #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MAKER_WORD  = 16'h00BF,
  parameter logic [DATA_W-1:0] DEVICE_WORD = 16'h2788
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              id_valid_o,
  output logic [DATA_W-1:0] id_rdata_o
);
  logic hit;

  assign hit = id_mode_i && (rd_addr_i[ADDR_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid_o <= 1'b0;
      id_rdata_o <= '0;
    end else begin
      id_valid_o <= hit;
      if (!hit)
        id_rdata_o <= '0;
      else if (rd_addr_i[0])
        id_rdata_o <= DEVICE_WORD;
      else
        id_rdata_o <= MAKER_WORD;
    end
  end

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SECT_IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              start_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              id_mode_o,
  output logic              id_valid_o,
  output logic [DATA_W-1:0] id_rdata_o
);
  hit_t hit;
  op_e  op;

  cmd_match #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) match_i (
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .hit_o (hit)
  );

  cmdseq_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SECT_IDX_W(SECT_IDX_W)
  ) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .busy_i   (busy_i),
    .addr_i   (wr_addr_i),
    .data_i   (wr_data_i),
    .hit_i    (hit),
    .start_o  (start_o),
    .op_o     (op),
    .op_addr_o(op_addr_o),
    .op_data_o(op_data_o),
    .id_mode_o(id_mode_o)
  );

  assign op_o = op;

  id_reader #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) idr_i (
    .clk       (clk),
    .rst       (rst),
    .id_mode_i (id_mode_o),
    .rd_addr_i (rd_addr_i),
    .id_valid_o(id_valid_o),
    .id_rdata_o(id_rdata_o)
  );

endmodule

// File: rtl/cmdseq_decoder_chk.sv
module cmdseq_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic              busy_i,
  input logic              start_o,
  input logic [1:0]        op_o,
  input logic              id_mode_o,
  input logic              id_valid_o,
  input logic [DATA_W-1:0] id_rdata_o
);
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  assert_no_write_no_start_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> !start_o);

  assert_busy_no_start_R10: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !start_o);

  assert_busy_id_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(id_mode_o));

  assert_idle_id_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(id_mode_o));

  assert_start_has_op_R2: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (op_o != 2'd0));

  assert_id_read_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
    id_valid_o |-> $past(id_mode_o));

  assert_id_data_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !id_valid_o |-> (id_rdata_o == '0));

endmodule

bind cmdseq_decoder cmdseq_decoder_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .busy_i    (busy_i),
  .start_o   (start_o),
  .op_o      (op_o),
  .id_mode_o (id_mode_o),
  .id_valid_o(id_valid_o),
  .id_rdata_o(id_rdata_o)
);

// File: tb/cmdseq_decoder_tb.sv
module cmdseq_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 51;

  typedef struct packed {
    logic        busy;
    logic [15:0] a;
    logic [15:0] d;
    logic        es;
    logic [1:0]  eop;
    logic [15:0] ea;
    logic [15:0] ed;
    logic        eid;
    logic [3:0]  req;
  } vec_t;

  // Each entry is one bus write followed by the expected outputs.
  localparam vec_t VECS [NV] = '{
    // R2 program
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd2},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd2},
    '{1'b0,16'h5555,16'h00A0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd2},
    '{1'b0,16'h1234,16'hBEEF,1'b1,2'd1,16'h1234,16'hBEEF,1'b0,4'd2},
    // R3 don't-care bits
    '{1'b0,16'hD555,16'h12AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd3},
    '{1'b0,16'hAAAA,16'hFF55,1'b0,2'd0,16'h0,16'h0,1'b0,4'd3},
    '{1'b0,16'h5555,16'h00A0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd3},
    '{1'b0,16'h8001,16'h0F0F,1'b1,2'd1,16'h8001,16'h0F0F,1'b0,4'd3},
    // R4 chip erase
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd4},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd4},
    '{1'b0,16'h5555,16'h0080,1'b0,2'd0,16'h0,16'h0,1'b0,4'd4},
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd4},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd4},
    '{1'b0,16'h5555,16'h0010,1'b1,2'd3,16'h0000,16'h0000,1'b0,4'd4},
    // R5 sector erase
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd5},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd5},
    '{1'b0,16'h5555,16'h0080,1'b0,2'd0,16'h0,16'h0,1'b0,4'd5},
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd5},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd5},
    '{1'b0,16'h7ABC,16'h0030,1'b1,2'd2,16'h7800,16'h0000,1'b0,4'd5},
    // R9 abort, breaking write not re-evaluated
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h5555,16'h00A0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h4444,16'h5555,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    // R9 bad final erase code
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h5555,16'h0080,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    '{1'b0,16'h5555,16'h0020,1'b0,2'd0,16'h0,16'h0,1'b0,4'd9},
    // R6 enter identification
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd6},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd6},
    '{1'b0,16'h5555,16'h0090,1'b0,2'd0,16'h0,16'h0,1'b1,4'd6},
    // R8 single-write exit
    '{1'b0,16'h1234,16'h00F0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd8},
    // R7 keyed exit
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd7},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd7},
    '{1'b0,16'h5555,16'h0090,1'b0,2'd0,16'h0,16'h0,1'b1,4'd7},
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b1,4'd7},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b1,4'd7},
    '{1'b0,16'h5555,16'h00F0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd7},
    // R10 busy write inside a sequence is ignored
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10},
    '{1'b1,16'h0000,16'h0020,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10},
    '{1'b0,16'h5555,16'h00A0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10},
    '{1'b0,16'h00FF,16'hCAFE,1'b1,2'd1,16'h00FF,16'hCAFE,1'b0,4'd10},
    // R10 busy exit ignored
    '{1'b0,16'h5555,16'h00AA,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10},
    '{1'b0,16'h2AAA,16'h0055,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10},
    '{1'b0,16'h5555,16'h0090,1'b0,2'd0,16'h0,16'h0,1'b1,4'd10},
    '{1'b1,16'h0000,16'h00F0,1'b0,2'd0,16'h0,16'h0,1'b1,4'd10},
    '{1'b0,16'h0000,16'h00F0,1'b0,2'd0,16'h0,16'h0,1'b0,4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        start;
  logic [1:0]  op;
  logic [15:0] op_addr;
  logic [15:0] op_data;
  logic        id_mode;
  logic        id_valid;
  logic [15:0] id_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdseq_decoder dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .busy_i    (busy),
    .rd_addr_i (rd_addr),
    .start_o   (start),
    .op_o      (op),
    .op_addr_o (op_addr),
    .op_data_o (op_data),
    .id_mode_o (id_mode),
    .id_valid_o(id_valid),
    .id_rdata_o(id_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, sampled at posedge, outputs checked at next negedge.
  task automatic bus_write(input logic b, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; busy = b; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic id_read(input logic [15:0] a, input logic ev, input logic [15:0] ed);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    check("R6", "id_valid", {31'd0, id_valid}, {31'd0, ev});
    check("R6", "id_rdata", {16'd0, id_rdata}, {16'd0, ed});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state while reset is held
    check("R1", "start in reset", {31'd0, start}, 32'd0);
    check("R1", "id_mode in reset", {31'd0, id_mode}, 32'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "op after reset", {30'd0, op}, 32'd0);
    check("R1", "id_valid after reset", {31'd0, id_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      bus_write(VECS[i].busy, VECS[i].a, VECS[i].d);
      check(rq, $sformatf("start v%0d", i), {31'd0, start}, {31'd0, VECS[i].es});
      check(rq, $sformatf("id_mode v%0d", i), {31'd0, id_mode}, {31'd0, VECS[i].eid});
      if (VECS[i].es) begin
        check(rq, $sformatf("op v%0d", i), {30'd0, op}, {30'd0, VECS[i].eop});
        check(rq, $sformatf("op_addr v%0d", i), {16'd0, op_addr}, {16'd0, VECS[i].ea});
        check(rq, $sformatf("op_data v%0d", i), {16'd0, op_data}, {16'd0, VECS[i].ed});
        // R11 pulse lasts one cycle
        @(posedge clk);
        @(negedge clk);
        check("R11", "start width", {31'd0, start}, 32'd0);
      end
    end

    // R6 identification reads
    id_read(16'h0000, 1'b0, 16'h0000);
    bus_write(1'b0, 16'h5555, 16'h00AA);
    bus_write(1'b0, 16'h2AAA, 16'h0055);
    bus_write(1'b0, 16'h5555, 16'h0090);
    check("R6", "id_mode on", {31'd0, id_mode}, 32'd1);
    id_read(16'h0000, 1'b1, 16'h00BF);
    id_read(16'h0001, 1'b1, 16'h2788);
    id_read(16'h0002, 1'b0, 16'h0000);
    id_read(16'h8001, 1'b0, 16'h0000);
    // R8 exit then reads stop
    bus_write(1'b0, 16'h7777, 16'hAAF0);
    check("R8", "id_mode off", {31'd0, id_mode}, 32'd0);
    id_read(16'h0001, 1'b0, 16'h0000);

    // R11 no start without writes after an armed program
    bus_write(1'b0, 16'h5555, 16'h00AA);
    bus_write(1'b0, 16'h2AAA, 16'h0055);
    bus_write(1'b0, 16'h5555, 16'h00A0);
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      check("R11", "idle start", {31'd0, start}, 32'd0);
    end
    bus_write(1'b0, 16'h0100, 16'h0202);
    check("R2", "armed program after idle", {31'd0, start}, 32'd1);

    // R1 reset clears identification mode
    bus_write(1'b0, 16'h5555, 16'h00AA);
    bus_write(1'b0, 16'h2AAA, 16'h0055);
    bus_write(1'b0, 16'h5555, 16'h0090);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "id_mode after reset", {31'd0, id_mode}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule